// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Interrupts

A memory-mapped real-time clock core. It holds a 32-bit seconds counter that advances once every `TICKS_PER_SEC` pulses of an external tick input. It also holds two alarm compare registers, each with its own interrupt configuration. Software reaches all of this state through a simple single-cycle register bus. Writes take effect on the clock edge. Read data follows the address combinationally.

An alarm match latches an event bit in the status register. That bit holds until software acknowledges it by writing a 1 to its position. Writing zeros to the status register does nothing, so software can issue dummy zero writes to status before every real write without risk.

Each alarm can drive the interrupt line in two ways:
- with its latched event, when its alarm enable is set;
- with a periodic one-cycle pulse, either once per second or once per tick pulse.

A configuration register powers up with a non-zero low byte. This tells software that the clock still needs setting up.

Top module: `sec_rtc_core`

## Requirements
- R1: After reset the following hold: time reads 0, status reads 0, both interrupt configs read 0, correction reads 0, configuration reads `UNINIT_VAL` (low byte non-zero, 0xA5 by default), and `irq_o` is low.
- R2: The seconds counter increments by one on every `TICKS_PER_SEC`-th `tick_i` pulse. It wraps from 0xFFFFFFFF to 0.
- R3: A write to time loads the counter on that edge and restarts the tick phase. A full `TICKS_PER_SEC` further pulses are then needed for the next increment.
- R4: Word addresses decode as follows. Every other address reads 0.

  | Address | Register |
  |---|---|
  | 0x00 | status |
  | 0x04 | alarm-1 interrupt config |
  | 0x08 | alarm-2 interrupt config |
  | 0x0C | time |
  | 0x10 | alarm 1 |
  | 0x14 | alarm 2 |
  | 0x18 | correction (32-bit storage) |
  | 0x1C | configuration |

  Interrupt config registers keep bits [2:0] only.
- R5: Status bit 0 is the alarm-1 event and bit 1 is the alarm-2 event. An event is set when a one-second increment makes the counter equal that alarm's value. Loading the counter with a write never sets an event.
- R6: An event stays set until a status write carries 1 in its bit position. Status writes with 0 in that bit leave it unchanged. When set and acknowledge coincide, set wins.
- R7: Interrupt config bit 0 is alarm enable, bit 1 is periodic enable, and bit 2 is the 1 Hz select. `irq_o` is the OR, over both alarms, of (event AND alarm enable) and of each alarm's periodic pulse.
- R8: When periodic enable is set, a one-cycle pulse appears on `irq_o` on the edge after each second step (bit 2 = 1) or after each `tick_i` pulse (bit 2 = 0).
- R9: Writing 0 to an interrupt config register removes every interrupt contribution of that alarm.
- R10: The configuration register stores whatever is written. Writing 0 clears the uninitialized indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick pulse, one cycle per tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps 0 to 12 tick pulses after a time load. This separates the increment threshold from off-by-one prescaler faults, and a load from mid-phase shows whether the phase is cleared.

Alarm offsets of 0 to 3 seconds are swept against each second step. This separates the "new value equals alarm" rule from comparing the old value, and from setting an event on a load.

Dummy zero, single-bit and mixed status writes show whether acknowledge is per bit. Masked against enabled alarms, and fast against 1 Hz periodic settings, show how each config bit routes into the interrupt.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_STATUS = 5'h00;
  localparam logic [ADDR_W-1:0] A_ICFG1  = 5'h04;
  localparam logic [ADDR_W-1:0] A_ICFG2  = 5'h08;
  localparam logic [ADDR_W-1:0] A_TIME   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_ALM1   = 5'h10;
  localparam logic [ADDR_W-1:0] A_ALM2   = 5'h14;
  localparam logic [ADDR_W-1:0] A_CORR   = 5'h18;
  localparam logic [ADDR_W-1:0] A_CONF   = 5'h1C;

  typedef struct packed {
    logic hz_sel;
    logic per_en;
    logic alm_en;
  } irq_cfg_t;
endpackage

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_o = tick_i && (cnt_q == LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST)    cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R3
  phase_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm
  import sec_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              alm_we_i,
  input  logic              ack_we_i,
  input  logic              ack_bit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inc_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] next_time_i,
  output logic [DATA_W-1:0] alm_o,
  output irq_cfg_t          cfg_o,
  output logic              evt_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] alm_q;
  irq_cfg_t          cfg_q;
  logic              evt_q, per_q, hit;

  assign hit = inc_i && (next_time_i == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
      cfg_q <= '0;
      evt_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      if (alm_we_i) alm_q <= wdata_i;
      if (cfg_we_i) cfg_q <= irq_cfg_t'(wdata_i[2:0]);
      if (hit)                        evt_q <= 1'b1;
      else if (ack_we_i && ack_bit_i) evt_q <= 1'b0;
      per_q <= cfg_q.per_en && (cfg_q.hz_sel ? inc_i : tick_i);
    end
  end

  assign alm_o = alm_q;
  assign cfg_o = cfg_q;
  assign evt_o = evt_q;
  assign irq_o = (evt_q && cfg_q.alm_en) || per_q;

  // R5
  alarm_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> evt_o);
  // R6
  zero_ack_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !ack_bit_i && evt_q) |=> evt_o);
  // R9
  cfg_clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wdata_i[2:0] == 3'b000) |=> ##1 !irq_o);
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
  import sec_rtc_pkg::*;
#(
  parameter int          TICKS_PER_SEC = 32768,
  parameter int          N_ALARM       = 2,
  parameter logic [31:0] UNINIT_VAL    = 32'h0000_00A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] time_q, corr_q, conf_q, next_time;
  logic              time_ld, sec_stb, inc;
  logic [N_ALARM-1:0]              evt, alm_irq;
  logic [N_ALARM-1:0][DATA_W-1:0]  alm_val;
  irq_cfg_t [N_ALARM-1:0]          cfg_val;

  assign time_ld   = we_i && (addr_i == A_TIME);
  assign next_time = time_q + 1'b1;
  assign inc       = sec_stb && !time_ld;

  sec_rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (time_ld),
    .sec_o  (sec_stb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      corr_q <= '0;
      conf_q <= UNINIT_VAL;
    end else begin
      if (time_ld)  time_q <= wdata_i;
      else if (inc) time_q <= next_time;
      if (we_i && addr_i == A_CORR) corr_q <= wdata_i;
      if (we_i && addr_i == A_CONF) conf_q <= wdata_i;
    end
  end

  for (genvar k = 0; k < N_ALARM; k++) begin : g_alm
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(A_ICFG1 + 4 * k);
    localparam logic [ADDR_W-1:0] ALM_A = ADDR_W'(A_ALM1 + 4 * k);
    sec_rtc_alarm u_alm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (we_i && addr_i == CFG_A),
      .alm_we_i    (we_i && addr_i == ALM_A),
      .ack_we_i    (we_i && addr_i == A_STATUS),
      .ack_bit_i   (wdata_i[k]),
      .wdata_i     (wdata_i),
      .inc_i       (inc),
      .tick_i      (tick_i),
      .next_time_i (next_time),
      .alm_o       (alm_val[k]),
      .cfg_o       (cfg_val[k]),
      .evt_o       (evt[k]),
      .irq_o       (alm_irq[k])
    );
  end

  assign irq_o = |alm_irq;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STATUS: rdata_o = DATA_W'(evt);
      A_ICFG1:  rdata_o = DATA_W'(cfg_val[0]);
      A_ICFG2:  rdata_o = DATA_W'(cfg_val[N_ALARM-1]);
      A_TIME:   rdata_o = time_q;
      A_ALM1:   rdata_o = alm_val[0];
      A_ALM2:   rdata_o = alm_val[N_ALARM-1];
      A_CORR:   rdata_o = corr_q;
      A_CONF:   rdata_o = conf_q;
      default:  rdata_o = '0;
    endcase
  end

  // R3
  time_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_ld |=> time_q == $past(wdata_i));
  // R2
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!time_ld && !sec_stb) |=> $stable(time_q));
  // R2
  time_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |=> time_q == $past(time_q) + 32'd1);
endmodule

// File: tb/sec_rtc_core_test.sv
module sec_rtc_core_test;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sec_rtc_core #(.TICKS_PER_SEC(TPS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0; #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
      @(negedge clk); tick = 1'b0; #1;
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk); #1;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h0C, v); chk("R1 time", v, 0);
    rd(5'h00, v); chk("R1 status", v, 0);
    rd(5'h04, v); chk("R1 icfg1", v, 0);
    rd(5'h08, v); chk("R1 icfg2", v, 0);
    rd(5'h18, v); chk("R1 corr", v, 0);
    rd(5'h1C, v); chk("R1 conf", v, 32'hA5);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 sweep of tick counts after load
    for (int k = 0; k <= 12; k++) begin
      wr(5'h0C, 32'd100);
      ticks(k);
      rd(5'h0C, v); chk("R2 count", v, 32'd100 + 32'(k / TPS));
    end
    wr(5'h0C, 32'hFFFF_FFFF); ticks(TPS);
    rd(5'h0C, v); chk("R2 wrap", v, 0);

    // R3 phase restart
    wr(5'h0C, 32'd50); ticks(2);
    wr(5'h0C, 32'd60); ticks(TPS - 1);
    rd(5'h0C, v); chk("R3 phase kept", v, 32'd60);
    ticks(1);
    rd(5'h0C, v); chk("R3 phase step", v, 32'd61);

    // R4 map
    wr(5'h04, 32'hFFFF_FFFD); wr(5'h08, 32'h3);
    wr(5'h10, 32'h1234_5678); wr(5'h14, 32'hCAFE_0001); wr(5'h18, 32'hDEAD_BEEF);
    rd(5'h04, v); chk("R4 icfg1", v, 32'h5);
    rd(5'h08, v); chk("R4 icfg2", v, 32'h3);
    rd(5'h10, v); chk("R4 alm1", v, 32'h1234_5678);
    rd(5'h14, v); chk("R4 alm2", v, 32'hCAFE_0001);
    rd(5'h18, v); chk("R4 corr", v, 32'hDEAD_BEEF);
    rd(5'h01, v); chk("R4 unmapped", v, 0);
    // R10 config storage
    wr(5'h1C, 32'h0000_1100); rd(5'h1C, v); chk("R10 conf store", v, 32'h1100);
    wr(5'h1C, 0); rd(5'h1C, v); chk("R10 conf clear", v, 0);

    // R5 / R6 / R7 alarm events
    wr(5'h04, 0); wr(5'h08, 0); wr(5'h00, 3);
    wr(5'h10, 20); wr(5'h14, 20); wr(5'h04, 1); wr(5'h0C, 18);
    ticks(TPS);
    rd(5'h00, v); chk("R5 no early event", v, 0);
    chk("R7 irq idle", {31'b0, irq}, 0);
    ticks(TPS);
    rd(5'h00, v); chk("R5 both events", v, 3);
    chk("R7 irq alarm1", {31'b0, irq}, 1);
    wr(5'h00, 0); wr(5'h00, 0);
    rd(5'h00, v); chk("R6 zero write keeps", v, 3);
    chk("R6 irq kept", {31'b0, irq}, 1);
    wr(5'h00, 1);
    rd(5'h00, v); chk("R6 ack bit0", v, 2);
    chk("R7 masked alarm2", {31'b0, irq}, 0);
    wr(5'h08, 1); chk("R7 alarm2 enabled", {31'b0, irq}, 1);
    wr(5'h08, 0); chk("R9 cfg zero", {31'b0, irq}, 0);
    wr(5'h00, 2); rd(5'h00, v); chk("R6 ack bit1", v, 0);
    wr(5'h0C, 20); rd(5'h00, v); chk("R5 load no event", v, 0);

    // R5 offset sweep
    for (int d = 0; d < 4; d++) begin
      wr(5'h10, 32'd200 + 32'(d)); wr(5'h0C, 200); wr(5'h00, 3);
      for (int s = 1; s <= 4; s++) begin
        ticks(TPS);
        rd(5'h00, v);
        chk("R5 offset sweep", v & 1, (d > 0 && s >= d) ? 1 : 0);
      end
    end
    wr(5'h00, 3); wr(5'h04, 0);

    // R8 periodic
    wr(5'h0C, 0); wr(5'h04, 32'h2);
    chk("R8 fast idle", {31'b0, irq}, 0);
    ticks(1); chk("R8 fast pulse", {31'b0, irq}, 1);
    idle();   chk("R8 fast one cycle", {31'b0, irq}, 0);
    wr(5'h0C, 0); wr(5'h04, 32'h6);
    for (int i = 0; i < TPS - 1; i++) begin
      ticks(1); chk("R8 1hz no pulse", {31'b0, irq}, 0);
    end
    ticks(1); chk("R8 1hz pulse", {31'b0, irq}, 1);
    idle();   chk("R8 1hz one cycle", {31'b0, irq}, 0);
    wr(5'h04, 0);
    for (int i = 0; i < TPS; i++) begin
      ticks(1); chk("R9 periodic off", {31'b0, irq}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule